// File: doc/BRIEF.md
# Multicast Hash Receive Address Filter

This block decides whether a received Ethernet frame should be kept, looking only at its 6-byte destination address. The address enters one byte per accepted strobe, first byte first, with a start marker on the first byte. While the bytes stream in, the block matches them against a programmed station address. It also runs a least-significant-bit-first CRC-32 over them, and it notes whether the address is multicast or all ones. One cycle after the sixth byte it gives a single-cycle verdict.

Multicast frames are filtered through a 64-entry hash table, held as four 16-bit words. The top six bits of the finished CRC select one table bit. Unicast frames must match the station address exactly. A promiscuous control accepts everything, and broadcast is always accepted. Configuration is a simple write port that selects one 16-bit register per write.

Top module: `mcast_addr_filter`

## Requirements
- R1: After reset `dec_valid` is low, promiscuous mode and hash enable are off, and all table and station words are zero, so a non-broadcast multicast address is rejected.
- R2: `dec_valid` is high for exactly one cycle, in the cycle after the sixth address byte is taken. It is never high while bytes one to five are arriving.
- R3: The CRC starts at all ones and takes each byte LSB first. For each bit, it shifts right and XORs 0xEDB88320 when the CRC LSB differs from the data bit. The index is CRC bits 31:26. Bits 5:4 select table word 0..3, and bits 3:0 select the bit within that word. With hashing enabled, a multicast address is accepted exactly when that bit is 1.
- R4: With hash enable off, a non-broadcast multicast address is rejected even when its table bit is set.
- R5: With hash enable on and all four table words at 0xFFFF, every multicast address is accepted.
- R6: An address is multicast when bit 0 of its first byte is 1. A unicast address is accepted only when all six bytes equal the station address. Station word 0 holds bytes 0 and 1, word 1 holds bytes 2 and 3, and word 2 holds bytes 4 and 5, with the earlier byte in bits 15:8.
- R7: The all-ones address is accepted in every mode, even with hashing off and the table empty.
- R8: With promiscuous mode on, every address is accepted.
- R9: A start marker in the middle of an address discards the partial address and begins a new one. Cycles with `addr_valid` low between bytes are ignored.
- R10: Writes use `cfg_sel`: 0..3 are table words 0..3, 4..6 are station words 0..2, and 7 is the mode word (bit 0 promiscuous, bit 1 hash enable). A write takes effect in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select for the write |
| cfg_wdata | input | 16 | Write data |
| addr_start | input | 1 | Marks the first byte of an address (qualified by addr_valid) |
| addr_valid | input | 1 | Address byte strobe |
| addr_byte | input | 8 | Address byte, first destination byte first |
| dec_valid | output | 1 | Single-cycle verdict strobe |
| dec_accept | output | 1 | Verdict: 1 accept, 0 reject; meaningful with dec_valid |

## Verification
Each verdict is due exactly one clock after the edge that takes the sixth byte. Gap cycles with `addr_valid` low only push that edge later. The bench drives inputs on falling edges. It reads `dec_valid` and `dec_accept` on the falling edge just after the sixth byte is taken, and it confirms `dec_valid` is low one cycle later and at every earlier byte. A configuration write counts from the edge after its strobe, and the bench finishes each write before it sends the next address.

// File: rtl/maf_pkg.sv
package maf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int WORD_W     = 16;
  localparam int HASH_WORDS = 4;
  localparam int STA_WORDS  = (ADDR_BYTES * 8) / WORD_W;
  localparam int WSEL_W     = $clog2(HASH_WORDS);
  localparam int BSEL_W     = $clog2(WORD_W);
  localparam int IDX_W      = WSEL_W + BSEL_W;
  localparam int SEL_W      = 3;
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
  localparam int CRC_W      = 32;

  localparam logic [SEL_W-1:0] SEL_STA0 = 3'd4;
  localparam logic [SEL_W-1:0] SEL_MODE = 3'd7;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [HASH_WORDS-1:0][WORD_W-1:0] hash_tbl_t;
  typedef logic [STA_WORDS-1:0][WORD_W-1:0]  sta_tbl_t;
endpackage

// File: rtl/maf_cfg_regs.sv
module maf_cfg_regs
  import maf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [SEL_W-1:0]     sel,
  input  logic [WORD_W-1:0]    wdata,
  output hash_tbl_t            hash_tbl,
  output sta_tbl_t             sta_tbl,
  output logic                 promisc,
  output logic                 hash_en
);
  for (genvar gi = 0; gi < HASH_WORDS; gi++) begin : g_hash
    always_ff @(posedge clk) begin
      if (rst) hash_tbl[gi] <= '0;
      else if (we && sel == SEL_W'(gi)) hash_tbl[gi] <= wdata;
    end
  end

  for (genvar gj = 0; gj < STA_WORDS; gj++) begin : g_sta
    always_ff @(posedge clk) begin
      if (rst) sta_tbl[gj] <= '0;
      else if (we && sel == SEL_STA0 + SEL_W'(gj)) sta_tbl[gj] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      promisc <= 1'b0;
      hash_en <= 1'b0;
    end else if (we && sel == SEL_MODE) begin
      promisc <= wdata[0];
      hash_en <= wdata[1];
    end
  end

  // R10: a mode write shows up on the next cycle
  assert_mode_write_R10: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_MODE) |=> (promisc == $past(wdata[0]) && hash_en == $past(wdata[1])));
endmodule

// File: rtl/maf_crc_step.sv
module maf_crc_step
  import maf_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = CRC_POLY_REFL
) (
  input  logic [CRC_W-1:0] crc_in,
  input  logic [7:0]       data,
  output logic [CRC_W-1:0] crc_out
);
  always_comb begin
    logic [CRC_W-1:0] c;
    c = crc_in;
    for (int k = 0; k < 8; k++) begin
      if (c[0] ^ data[k]) c = (c >> 1) ^ POLY;
      else                c = c >> 1;
    end
    crc_out = c;
  end
endmodule

// File: rtl/maf_decide.sv
module maf_decide
  import maf_pkg::*;
(
  input  logic [CRC_W-1:0] crc,
  input  hash_tbl_t        hash_tbl,
  input  logic             is_mcast,
  input  logic             is_bcast,
  input  logic             sta_match,
  input  logic             promisc,
  input  logic             hash_en,
  output logic             accept
);
  logic [IDX_W-1:0]  idx;
  logic [WSEL_W-1:0] wsel;
  logic [BSEL_W-1:0] bsel;
  logic              tbl_hit;

  always_comb begin
    idx     = crc[CRC_W-1 -: IDX_W];
    wsel    = idx[IDX_W-1 -: WSEL_W];
    bsel    = idx[BSEL_W-1:0];
    tbl_hit = hash_tbl[wsel][bsel];
    if (promisc || is_bcast) accept = 1'b1;
    else if (is_mcast)       accept = hash_en && tbl_hit;
    else                     accept = sta_match;
  end
endmodule

// File: rtl/mcast_addr_filter.sv
module mcast_addr_filter
  import maf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              addr_start,
  input  logic              addr_valid,
  input  logic [7:0]        addr_byte,
  output logic              dec_valid,
  output logic              dec_accept
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] DONE_CNT = CNT_W'(ADDR_BYTES);

  hash_tbl_t hash_tbl;
  sta_tbl_t  sta_tbl;
  logic      promisc, hash_en;

  maf_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .hash_tbl(hash_tbl), .sta_tbl(sta_tbl), .promisc(promisc), .hash_en(hash_en)
  );

  logic [CNT_W-1:0] cnt_q, cur_idx;
  logic [CRC_W-1:0] crc_q, crc_in, crc_nx;
  logic             match_q, ones_q, mcast_q;
  logic             match_nx, ones_nx, mcast_nx;
  logic             first, take, last, accept_nx;
  logic [ADDR_BYTES*8-1:0] sta_flat;
  logic [7:0]       sta_byte;

  always_comb begin
    first   = addr_valid && addr_start;
    cur_idx = first ? '0 : cnt_q;
    take    = first || (addr_valid && cnt_q != '0 && cnt_q < DONE_CNT);
    last    = take && cur_idx == LAST_IDX;
    sta_flat = '0;
    for (int w = 0; w < STA_WORDS; w++)
      sta_flat[(STA_WORDS-1-w)*WORD_W +: WORD_W] = sta_tbl[w];
    sta_byte = sta_flat[(ADDR_BYTES-1-int'(cur_idx))*8 +: 8];
    crc_in   = first ? '1 : crc_q;
    match_nx = (first ? 1'b1 : match_q) && (addr_byte == sta_byte);
    ones_nx  = (first ? 1'b1 : ones_q) && (addr_byte == 8'hFF);
    mcast_nx = first ? addr_byte[0] : mcast_q;
  end

  maf_crc_step u_crc (.crc_in(crc_in), .data(addr_byte), .crc_out(crc_nx));

  maf_decide u_dec (
    .crc(crc_nx), .hash_tbl(hash_tbl), .is_mcast(mcast_nx), .is_bcast(ones_nx),
    .sta_match(match_nx), .promisc(promisc), .hash_en(hash_en), .accept(accept_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      crc_q      <= '1;
      match_q    <= 1'b0;
      ones_q     <= 1'b0;
      mcast_q    <= 1'b0;
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid <= last;
      if (take) begin
        cnt_q   <= cur_idx + 1'b1;
        crc_q   <= crc_nx;
        match_q <= match_nx;
        ones_q  <= ones_nx;
        mcast_q <= mcast_nx;
      end
      if (last) dec_accept <= accept_nx;
    end
  end

  // R2: a verdict only follows a taken byte and never lasts two cycles
  assert_valid_follows_byte_R2: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(addr_valid));
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);
  // R8: promiscuous mode forces acceptance
  assert_promisc_accept_R8: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && $past(promisc)) |-> dec_accept);
  // R9: byte position stays inside the address
  assert_cnt_range_R9: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= DONE_CNT);
endmodule

// File: tb/mcast_addr_filter_test.sv
module mcast_addr_filter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        addr_start = 1'b0;
  logic        addr_valid = 1'b0;
  logic [7:0]  addr_byte = '0;
  logic        dec_valid, dec_accept;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench copies of configuration, kept from its own writes
  logic [15:0] m_hash [4];
  logic [47:0] m_sta;
  logic        m_promisc, m_hash_en;

  always #2.5 clk = ~clk;

  mcast_addr_filter uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .addr_start(addr_start), .addr_valid(addr_valid), .addr_byte(addr_byte),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b = a[47-8*i -: 8];
      for (int j = 0; j < 8; j++)
        c = (c[0] ^ b[j]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c = ref_crc(a);
    return c[31:26];
  endfunction

  function automatic logic ref_accept(input logic [47:0] a);
    logic [5:0] ix = ref_idx(a);
    if (m_promisc || a == 48'hFFFF_FFFF_FFFF) return 1'b1;
    if (a[40]) return m_hash_en && m_hash[ix[5:4]][ix[3:0]];
    return a == m_sta;
  endfunction

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (s < 3'd4) m_hash[s[1:0]] = d;
    else if (s == 3'd4) m_sta[47:32] = d;
    else if (s == 3'd5) m_sta[31:16] = d;
    else if (s == 3'd6) m_sta[15:0] = d;
    else begin m_promisc = d[0]; m_hash_en = d[1]; end
  endtask

  // Sends one address; checks pulse timing (R2) and returns the verdict
  task automatic send_addr(input logic [47:0] a, input int gap, output logic acc);
    bit early = 1'b0;
    logic pulse, after;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (dec_valid) early = 1'b1;
      addr_start = (i == 0); addr_valid = 1'b1; addr_byte = a[47-8*i -: 8];
      if (i < 5) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          if (dec_valid) early = 1'b1;
          addr_valid = 1'b0; addr_start = 1'b0;
        end
      end
    end
    @(negedge clk);
    addr_valid = 1'b0; addr_start = 1'b0;
    pulse = dec_valid; acc = dec_accept;
    @(negedge clk);
    after = dec_valid;
    chk(pulse && !early && !after, "R2 pulse timing", {early, pulse, after}, 3'b010);
  endtask

  task automatic expect_addr(input logic [47:0] a, input int gap, input string req);
    logic acc, exp;
    exp = ref_accept(a);
    send_addr(a, gap, acc);
    chk(acc === exp, req, acc, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(dec_valid === 1'b0, "R1 dec_valid after reset", dec_valid, 0);
    expect_addr(48'h0123_4567_89AB, 0, "R1 multicast rejected after reset");
  endtask

  task automatic t_unicast;
    wr(3'd4, 16'h0226); wr(3'd5, 16'h3A4B); wr(3'd6, 16'h5C6D);
    expect_addr(48'h0226_3A4B_5C6D, 0, "R6 exact unicast accepted");
    expect_addr(48'h0226_3A4B_5C6C, 0, "R6 last byte differs rejected");
    expect_addr(48'h0426_3A4B_5C6D, 0, "R6 first byte differs rejected");
    expect_addr(48'h2602_4B3A_6D5C, 0, "R6 swapped byte order rejected");
  endtask

  task automatic t_hash;
    logic [47:0] a = 48'h0100_5E00_00FB;
    logic [47:0] b;
    logic [5:0] ia = ref_idx(a);
    logic [15:0] w = 16'h0001 << ia[3:0];
    for (int k = 0; k < 4; k++) wr(3'(k), (k == int'(ia[5:4])) ? w : 16'h0000);
    wr(3'd7, 16'h0002);
    expect_addr(a, 0, "R3 multicast with table bit set accepted");
    b = a;
    for (int v = 0; v < 256; v++) begin
      b[7:0] = 8'(v);
      if (ref_idx(b) != ia) break;
    end
    expect_addr(b, 0, "R3 multicast with clear table bit rejected");
    expect_addr(a, 3, "R9 gaps between bytes ignored");
    wr(3'd7, 16'h0000);
    expect_addr(a, 0, "R4 hash disabled rejects multicast");
  endtask

  task automatic t_allmulti;
    for (int k = 0; k < 4; k++) wr(3'(k), 16'hFFFF);
    wr(3'd7, 16'h0002);
    expect_addr(48'h3333_0000_0001, 0, "R5 full table accepts multicast A");
    expect_addr(48'h01AB_CDEF_1234, 1, "R5 full table accepts multicast B");
    expect_addr(48'h0226_3A4B_5C6E, 0, "R6 unicast not helped by full table");
  endtask

  task automatic t_bcast;
    for (int k = 0; k < 4; k++) wr(3'(k), 16'h0000);
    wr(3'd7, 16'h0000);
    expect_addr(48'hFFFF_FFFF_FFFF, 0, "R7 broadcast always accepted");
  endtask

  task automatic t_promisc;
    wr(3'd7, 16'h0001);
    expect_addr(48'h00AA_BBCC_DDEE, 0, "R8 promiscuous accepts foreign unicast");
    expect_addr(48'h0155_6677_8899, 0, "R8 promiscuous accepts multicast");
    wr(3'd7, 16'h0000);
  endtask

  task automatic t_restart;
    @(negedge clk);
    addr_start = 1'b1; addr_valid = 1'b1; addr_byte = 8'h01;
    @(negedge clk); addr_start = 1'b0; addr_byte = 8'h22;
    @(negedge clk); addr_byte = 8'h33;
    @(negedge clk); addr_valid = 1'b0;
    chk(dec_valid === 1'b0, "R9 no verdict for partial address", dec_valid, 0);
    expect_addr(48'h0226_3A4B_5C6D, 0, "R9 restart gives fresh unicast verdict");
  endtask

  initial begin
    for (int k = 0; k < 4; k++) m_hash[k] = '0;
    m_sta = '0; m_promisc = 1'b0; m_hash_en = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_unicast();
    t_hash();
    t_allmulti();
    t_bcast();
    t_promisc();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule